// File: doc/BRIEF.md
# Speculative load conflict tracker

This block lets a statically scheduled processor move loads above stores whose addresses may alias. When a hoisted load executes, it is entered in a small set-associative table under a hashed address signature, together with its destination register, access size and low address bits. Each later store looks up its own hashed set and compares against every live entry there. An entry matches when the signatures agree and the byte ranges of the two accesses overlap. A match sets a per-register conflict flag.

At the place where the load originally stood, the program issues a check on the destination register. One cycle later the block reports whether the flag was set, which tells the program to branch to repair code. The check also clears the flag and frees the table slot that the register points to. Displacing a live entry because a set is full also sets the displaced register's flag, since that load is no longer tracked. After a context switch, a restore operation sets every flag. This makes sure every pending check takes the repair path.

One operation is accepted per cycle on a single request port.

Top module: `mcb_conflict_buffer`

## Requirements
- R1: The set index and the signature are each produced by an XOR hash. Output bit j is the XOR of the input bits i whose matrix bit [i*OUT_W+j] is 1. For the 4-input matrix with rows a3=1001, a2=0010, a1=1110, a0=0101, the result is h3=a3^a1, h2=a1^a0, h1=a2^a1 and h0=a3^a0, so input 1011 gives 0010.
- R2: Both hashes take only address bits above bit 2. The three lowest address bits play no part in choosing the set or the signature.
- R3: A preload (op_kind 0) clears the conflict flag of its destination register, even right after a restore.
- R4: A store (op_kind 1) sets the flag of every register whose live entry in the same set has an equal signature and an overlapping byte range. The byte range is 2^size bytes starting at the low 3 bits, where size 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R5: A store whose byte range does not overlap the entry's range sets no flag, even when its upper address is the same.
- R6: A store whose set index or signature differs from the entry's sets no flag.
- R7: A preload takes the lowest-numbered free way of its set, and filling free ways raises no flag. When the set is full, a pseudo-random way (taken from a free-running 8-bit LFSR) is replaced, and the displaced register's flag is set.
- R8: A check (op_kind 2) makes chk_valid high for exactly the next cycle. chk_taken then carries the register's flag, and the flag is cleared, so a second check of the same register is not taken.
- R9: A check frees the entry its register points to, so a later store to that address no longer flags the register.
- R10: A restore (op_kind 3) sets the flag of every register.
- R11: After reset, chk_valid is low, no flag is set and the table holds no live entry.
- R12: A check frees its pointed slot only if that slot still belongs to the checked register. A slot taken over by another preload stays live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request this cycle |
| op_kind | input | 2 | 0 preload, 1 store, 2 check, 3 restore |
| op_addr | input | ADDR_W | Access address (preload, store) |
| op_size | input | 2 | Access size code, bytes = 2^size |
| op_reg | input | REG_W | Destination register (preload) or checked register |
| chk_valid | output | 1 | Check result present |
| chk_taken | output | 1 | Checked register had a conflict |

## Verification
The bench builds the buffer with a 12-bit address, 4 sets of 2 ways, a 3-bit signature and 16 registers. With these values every 9-bit upper address can be swept against one preload, which exercises both hashes completely. Two-way sets let three preloads force a displacement. Every aligned pairing of load and store size and offset is swept, and the bench predicts each overlap from byte ranges. A standalone 4×4 hash instance is swept over all 16 inputs.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

  typedef enum logic [1:0] {
    OP_PRELOAD = 2'd0,
    OP_STORE   = 2'd1,
    OP_CHECK   = 2'd2,
    OP_RESTORE = 2'd3
  } mcb_op_e;

  // Bytes touched inside an 8-byte word by an aligned access.
  function automatic logic [7:0] byte_span(input logic [1:0] size, input logic [2:0] lo);
    logic [7:0] base;
    case (size)
      2'd0:    base = 8'h01;
      2'd1:    base = 8'h03;
      2'd2:    base = 8'h0F;
      default: base = 8'hFF;
    endcase
    return base << lo;
  endfunction

endpackage

// File: rtl/mcb_xor_hash.sv
module mcb_xor_hash #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 4,
  parameter logic [IN_W*OUT_W-1:0] MAT = '0
) (
  input  logic [IN_W-1:0]  in_i,
  output logic [OUT_W-1:0] out_o
);

  always_comb begin
    out_o = '0;
    for (int j = 0; j < OUT_W; j++) begin
      for (int i = 0; i < IN_W; i++) begin
        out_o[j] = out_o[j] ^ (in_i[i] & MAT[i*OUT_W + j]);
      end
    end
  end

endmodule

// File: rtl/mcb_lfsr.sv
module mcb_lfsr #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h5A
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state_o
);

  logic fb;
  assign fb = ^(state_o & TAPS);

  always_ff @(posedge clk) begin
    if (rst) state_o <= SEED;
    else     state_o <= {state_o[W-2:0], fb};
  end

endmodule

// File: rtl/mcb_victim_pick.sv
module mcb_victim_pick #(
  parameter int WAYS  = 8,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] rnd_i,
  output logic [WAY_W-1:0] way_o,
  output logic             evict_o
);

  logic found;

  always_comb begin
    found = 1'b0;
    way_o = rnd_i;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        found = 1'b1;
        way_o = WAY_W'(w);
      end
    end
    evict_o = !found;
  end

endmodule

// File: rtl/mcb_conflict_buffer.sv
module mcb_conflict_buffer #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 8,
  parameter int WAYS   = 8,
  parameter int SIG_W  = 5,
  parameter int NREG   = 64,
  parameter int LFSR_W = 8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h5A,
  parameter int REG_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [1:0]        op_size,
  input  logic [REG_W-1:0]  op_reg,
  output logic              chk_valid,
  output logic              chk_taken
);
  import mcb_pkg::*;

  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int HIN_W  = ADDR_W - 3;
  localparam int SLOT_W = SET_W + WAY_W;

  // Index matrix: input bit i feeds output bit i mod SET_W.
  function automatic logic [HIN_W*SET_W-1:0] mk_idx_mat();
    logic [HIN_W*SET_W-1:0] m;
    m = '0;
    for (int i = 0; i < HIN_W; i++) m[i*SET_W + (i % SET_W)] = 1'b1;
    return m;
  endfunction

  // Signature matrix: a rotated fold, full rank through its identity top rows.
  function automatic logic [HIN_W*SIG_W-1:0] mk_sig_mat();
    logic [HIN_W*SIG_W-1:0] m;
    m = '0;
    for (int i = 0; i < HIN_W; i++) m[i*SIG_W + ((i + i / SIG_W) % SIG_W)] = 1'b1;
    return m;
  endfunction

  localparam logic [HIN_W*SET_W-1:0] IDX_MAT = mk_idx_mat();
  localparam logic [HIN_W*SIG_W-1:0] SIG_MAT = mk_sig_mat();

  mcb_op_e kind;
  assign kind = mcb_op_e'(op_kind);

  // Table storage: payload without reset, valid bits with reset.
  logic [REG_W-1:0] ent_reg  [SETS][WAYS];
  logic [1:0]       ent_size [SETS][WAYS];
  logic [2:0]       ent_lo   [SETS][WAYS];
  logic [SIG_W-1:0] ent_sig  [SETS][WAYS];
  logic [WAYS-1:0]  ent_vld  [SETS];

  // Per-register conflict vector.
  logic [NREG-1:0]   cflag;
  logic [SLOT_W-1:0] cptr [NREG];

  logic [SET_W-1:0] set_idx;
  logic [SIG_W-1:0] op_sig;
  logic [7:0]       op_span;
  logic [WAYS-1:0]  way_hit;
  logic [WAY_W-1:0] pick_way;
  logic             pick_evict;
  logic [LFSR_W-1:0] rnd;
  logic [SET_W-1:0] ptr_set;
  logic [WAY_W-1:0] ptr_way;

  mcb_xor_hash #(.IN_W(HIN_W), .OUT_W(SET_W), .MAT(IDX_MAT)) u_idx_hash (
    .in_i (op_addr[ADDR_W-1:3]),
    .out_o(set_idx)
  );

  mcb_xor_hash #(.IN_W(HIN_W), .OUT_W(SIG_W), .MAT(SIG_MAT)) u_sig_hash (
    .in_i (op_addr[ADDR_W-1:3]),
    .out_o(op_sig)
  );

  mcb_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk    (clk),
    .rst    (rst),
    .state_o(rnd)
  );

  mcb_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
    .valid_i(ent_vld[set_idx]),
    .rnd_i  (rnd[WAY_W-1:0]),
    .way_o  (pick_way),
    .evict_o(pick_evict)
  );

  assign op_span = byte_span(op_size, op_addr[2:0]);
  assign ptr_set = cptr[op_reg][SLOT_W-1:WAY_W];
  assign ptr_way = cptr[op_reg][WAY_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    logic [7:0] ent_span;
    assign ent_span   = byte_span(ent_size[set_idx][w], ent_lo[set_idx][w]);
    assign way_hit[w] = ent_vld[set_idx][w]
                        && (ent_sig[set_idx][w] == op_sig)
                        && (|(ent_span & op_span));
  end

  // Payload and back-pointer writes.
  always_ff @(posedge clk) begin
    if (op_valid && kind == OP_PRELOAD) begin
      ent_reg [set_idx][pick_way] <= op_reg;
      ent_size[set_idx][pick_way] <= op_size;
      ent_lo  [set_idx][pick_way] <= op_addr[2:0];
      ent_sig [set_idx][pick_way] <= op_sig;
      cptr[op_reg]                <= {set_idx, pick_way};
    end
  end

  // Valid bits, conflict flags and the registered check result.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) ent_vld[s] <= '0;
      cflag     <= '0;
      chk_valid <= 1'b0;
      chk_taken <= 1'b0;
    end else begin
      chk_valid <= 1'b0;
      chk_taken <= 1'b0;
      if (op_valid) begin
        case (kind)
          OP_PRELOAD: begin
            ent_vld[set_idx][pick_way] <= 1'b1;
            if (pick_evict) cflag[ent_reg[set_idx][pick_way]] <= 1'b1;
            cflag[op_reg] <= 1'b0;
          end
          OP_STORE: begin
            for (int w = 0; w < WAYS; w++) begin
              if (way_hit[w]) cflag[ent_reg[set_idx][w]] <= 1'b1;
            end
          end
          OP_CHECK: begin
            chk_valid     <= 1'b1;
            chk_taken     <= cflag[op_reg];
            cflag[op_reg] <= 1'b0;
            if (ent_reg[ptr_set][ptr_way] == op_reg) ent_vld[ptr_set][ptr_way] <= 1'b0;
          end
          OP_RESTORE: cflag <= '1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/mcb_conflict_buffer_chk.sv
module mcb_conflict_buffer_chk #(
  parameter int REG_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [1:0]       op_kind,
  input logic [REG_W-1:0] op_reg,
  input logic             chk_valid,
  input logic             chk_taken
);

  p_chk_follows_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 2'd2) |=> chk_valid);

  p_chk_only_after_check_r8: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && op_kind == 2'd2) |=> !chk_valid);

  p_taken_implies_valid_r8: assert property (@(posedge clk) disable iff (rst)
    chk_taken |-> chk_valid);

  p_second_check_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 2'd2) ##1 (op_valid && op_kind == 2'd2 && op_reg == $past(op_reg))
    |=> !chk_taken);

  p_preload_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 2'd0) ##1 (op_valid && op_kind == 2'd2 && op_reg == $past(op_reg))
    |=> !chk_taken);

  p_restore_flags_all_r10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 2'd3) ##1 (op_valid && op_kind == 2'd2)
    |=> chk_taken);

  p_reset_quiet_r11: assert property (@(posedge clk)
    $past(rst) |-> !chk_valid);

endmodule

bind mcb_conflict_buffer mcb_conflict_buffer_chk #(.REG_W(REG_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .op_kind  (op_kind),
  .op_reg   (op_reg),
  .chk_valid(chk_valid),
  .chk_taken(chk_taken)
);

// File: tb/mcb_conflict_buffer_tb.sv
module mcb_conflict_buffer_tb_top;

  localparam int AW = 12;
  localparam int NS = 4;
  localparam int NW = 2;
  localparam int SW = 3;
  localparam int NR = 16;
  localparam int RW = 4;
  localparam int HW = AW - 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [1:0]    op_kind = '0;
  logic [AW-1:0] op_addr = '0;
  logic [1:0]    op_size = '0;
  logic [RW-1:0] op_reg = '0;
  logic          chk_valid;
  logic          chk_taken;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mcb_conflict_buffer #(
    .ADDR_W(AW), .SETS(NS), .WAYS(NW), .SIG_W(SW), .NREG(NR)
  ) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .op_size(op_size), .op_reg(op_reg),
    .chk_valid(chk_valid), .chk_taken(chk_taken)
  );

  // Standalone 4x4 hash with the example matrix.
  logic [3:0] hv = '0;
  logic [3:0] ho;
  mcb_xor_hash #(.IN_W(4), .OUT_W(4), .MAT(16'b1001_0010_1110_0101)) hash4_i (
    .in_i(hv), .out_o(ho)
  );

  function automatic logic [1:0] b_idx(input logic [HW-1:0] u);
    logic [1:0] r = '0;
    for (int i = 0; i < HW; i++) r[i % 2] = r[i % 2] ^ u[i];
    return r;
  endfunction

  function automatic logic [SW-1:0] b_sig(input logic [HW-1:0] u);
    logic [SW-1:0] r = '0;
    for (int i = 0; i < HW; i++) r[(i + i / SW) % SW] = r[(i + i / SW) % SW] ^ u[i];
    return r;
  endfunction

  function automatic logic [AW-1:0] mk_addr(input logic [HW-1:0] u, input logic [2:0] lo);
    return {u, lo};
  endfunction

  task automatic drive(input logic [1:0] k, input logic [AW-1:0] a,
                       input logic [1:0] s, input int r);
    @(negedge clk);
    op_valid = 1'b1;
    op_kind  = k;
    op_addr  = a;
    op_size  = s;
    op_reg   = RW'(r);
    @(posedge clk);
    #1;
    op_valid = 1'b0;
  endtask

  task automatic do_chk(input int r, input bit exp, input string tag);
    drive(2'd2, '0, 2'd0, r);
    checks++;
    if (chk_valid !== 1'b1 || chk_taken !== exp) begin
      errors++;
      $display("FAIL %s: reg %0d valid=%0b taken=%0b expected valid=1 taken=%0b",
               tag, r, chk_valid, chk_taken, exp);
    end
  endtask

  task automatic get_chk(input int r, output bit t);
    drive(2'd2, '0, 2'd0, r);
    t = chk_taken;
  endtask

  task automatic expect_eq(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    logic [HW-1:0] ua, ub, uc, ud, ue;
    bit ta, tb_;
    int found;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R11: reset state
    expect_eq(int'(chk_valid), 0, "R11 chk_valid after reset");
    drive(2'd1, mk_addr(9'h055, 3'd0), 2'd3, 0);
    for (int r = 0; r < NR; r++) do_chk(r, 1'b0, "R11 no flag after reset");

    // R1: hash matrix sweep
    for (int v = 0; v < 16; v++) begin
      logic [3:0] a, e;
      a  = 4'(v);
      hv = a;
      #1;
      e = {a[3] ^ a[1], a[1] ^ a[0], a[2] ^ a[1], a[3] ^ a[0]};
      expect_eq(int'(ho), int'(e), "R1 hash sweep");
    end
    hv = 4'b1011;
    #1;
    expect_eq(int'(ho), 2, "R1 example 1011");

    // R10: restore sets all flags; R8: second check clear
    drive(2'd3, '0, 2'd0, 0);
    for (int r = 0; r < NR; r++) do_chk(r, 1'b1, "R10 restore flag");
    do_chk(3, 1'b0, "R8 flag cleared by check");

    // R3: preload clears flag after restore
    drive(2'd3, '0, 2'd0, 0);
    drive(2'd0, mk_addr(9'h00A, 3'd0), 2'd2, 4);
    do_chk(4, 1'b0, "R3 preload clears flag");
    for (int r = 0; r < NR; r++) if (r != 4) get_chk(r, ta);

    // R4/R5: all aligned size/offset pairings on one upper address
    for (int sp = 0; sp < 4; sp++)
      for (int lp = 0; lp < 8; lp += (1 << sp))
        for (int ss = 0; ss < 4; ss++)
          for (int ls = 0; ls < 8; ls += (1 << ss)) begin
            bit ov;
            ov = (lp < ls + (1 << ss)) && (ls < lp + (1 << sp));
            drive(2'd0, mk_addr(9'h055, 3'(lp)), 2'(sp), 2);
            drive(2'd1, mk_addr(9'h055, 3'(ls)), 2'(ss), 0);
            do_chk(2, ov, ov ? "R4 overlap flags" : "R5 disjoint bytes ignored");
          end

    // R6/R2: every upper address against one preload, store low bits varied
    for (int u = 0; u < (1 << HW); u++) begin
      bit hit;
      hit = (b_idx(9'(u)) == b_idx(9'h123)) && (b_sig(9'(u)) == b_sig(9'h123));
      drive(2'd0, mk_addr(9'h123, 3'd0), 2'd3, 6);
      drive(2'd1, mk_addr(9'(u), 3'(u)), 2'd0, 0);
      do_chk(6, hit, hit ? "R2 same hash flags" : "R6 other set or signature");
    end

    // R7/R12/R9: displacement rounds
    for (int round = 0; round < 4; round++) begin
      logic [1:0] s;
      s = 2'(round);
      found = 0;
      ua = '0; ub = '0; uc = '0;
      for (int u = 0; u < (1 << HW); u++) begin
        if (b_idx(9'(u)) == s) begin
          if (found == 0) begin ua = 9'(u); found = 1; end
          else if (found == 1 && b_sig(9'(u)) != b_sig(ua)) begin ub = 9'(u); found = 2; end
          else if (found == 2 && b_sig(9'(u)) != b_sig(ua) && b_sig(9'(u)) != b_sig(ub)) begin
            uc = 9'(u); found = 3;
          end
        end
      end
      drive(2'd0, mk_addr(ua, 3'd0), 2'd3, 8);
      drive(2'd0, mk_addr(ub, 3'd0), 2'd3, 9);
      drive(2'd0, mk_addr(uc, 3'd0), 2'd3, 10);
      get_chk(8, ta);
      get_chk(9, tb_);
      expect_eq(int'(ta) + int'(tb_), 1, "R7 exactly one displaced");
      drive(2'd1, mk_addr(uc, 3'd0), 2'd3, 0);
      do_chk(10, 1'b1, "R12 survivor slot still live");
      drive(2'd1, mk_addr(uc, 3'd0), 2'd3, 0);
      do_chk(10, 1'b0, "R9 checked entry freed");
    end

    // R7: free ways filled without any flag
    found = 0;
    ud = '0; ue = '0;
    for (int u = 0; u < (1 << HW); u++) begin
      if (b_idx(9'(u)) == 2'd1) begin
        if (found == 0) begin ud = 9'(u); found = 1; end
        else if (found == 1 && b_sig(9'(u)) != b_sig(ud)) begin ue = 9'(u); found = 2; end
      end
    end
    drive(2'd0, mk_addr(ud, 3'd0), 2'd3, 11);
    drive(2'd0, mk_addr(ue, 3'd0), 2'd3, 12);
    do_chk(11, 1'b0, "R7 free way no flag");
    do_chk(12, 1'b0, "R7 free way no flag");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule